// File: doc/BRIEF.md
# Parallel Flash Bus-Operation Decoder

This block is the device-side front end of an asynchronous parallel NOR-style flash port. A fast system clock samples the active-low chip-select, write-strobe and output-strobe pins. Each pin passes through a two-flop synchronizer. The chip-select and write-strobe then pass through a glitch filter. The block classifies the bus every cycle as standby, output disable, read, write or automatic standby. It drives the enable for the tri-state data pins, and a low-power flag that rises when the chip is deselected or the strobes have been quiet long enough.

On a write, the address is taken when the combined write condition begins, meaning both chip-select and write-strobe are low. The data is taken when that condition ends, which happens as soon as either strobe returns high. A completed write is handed to a downstream command interpreter as a one-clock pulse carrying both values. A write during which the output strobe was seen low is reported as a protocol error, and its data is dropped.

The filter length and the inactivity window are set in picoseconds and converted to sample counts from the sampling period. With the defaults (2000 ps sampling, 5000 ps filter, 150000 ps window) this gives 3 and 75 samples.

Top module: `flash_busop_fe`

## Requirements
- R1: After reset, `bus_op` is 0 (standby), `dq_oe` is 0, and neither `wr_valid` nor `wr_err` pulses.
- R2: With chip-select low, output strobe low and write strobe high, `bus_op` reads 2 (read), `dq_oe` is 1 and `dq_o` follows `rd_data_i`.
- R3: With chip-select low and both other strobes high, `bus_op` reads 1 (output disable) and `dq_oe` is 0.
- R4: With chip-select high, `bus_op` reads 0 (standby) and `dq_oe` is 0, whatever the other strobes do.
- R5: While chip-select and write strobe are both low with the output strobe high, `bus_op` reads 3 (write). The address present when the later of the two falls is captured. The data present when the earlier of the two rises is captured. Both are then presented together on a single one-cycle `wr_valid` pulse.
- R6: If the output strobe is low at any time during a write, that write ends with a one-cycle `wr_err` pulse and no `wr_valid` pulse.
- R7: A pulse on chip-select or write strobe shorter than the filter length (3 samples by default) has no effect on `bus_op`, `dq_oe`, `wr_valid` or `wr_err`.
- R8: With chip-select low and no strobe transition for the inactivity window (75 samples by default), `bus_op` reads 4 (automatic standby) and `low_pwr` is 1. An ongoing read keeps `dq_oe` at 1.
- R9: While `busy` is 1, `low_pwr` is 0 in every bus state.
- R10: Any strobe transition restarts the inactivity window, so `low_pwr` drops out of automatic standby.
- R11: In standby with `busy` low, `low_pwr` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip-select pin, active low, asynchronous |
| we_n | input | 1 | Write-strobe pin, active low, asynchronous |
| oe_n | input | 1 | Output-strobe pin, active low, asynchronous |
| busy | input | 1 | Program or erase in progress |
| addr_i | input | ADDR_W | Address pins |
| dq_i | input | DATA_W | Data pins, input side |
| rd_data_i | input | DATA_W | Read data from the array side |
| dq_o | output | DATA_W | Data pins, output side |
| dq_oe | output | 1 | Tri-state enable for the data pins |
| bus_op | output | 3 | Bus state: 0 standby, 1 output disable, 2 read, 3 write, 4 automatic standby |
| low_pwr | output | 1 | Low-power flag |
| wr_valid | output | 1 | One-cycle pulse for a completed write |
| wr_addr | output | ADDR_W | Captured write address |
| wr_data | output | DATA_W | Captured write data |
| wr_err | output | 1 | One-cycle pulse for a write broken by a low output strobe |

## Verification
The assertions rely on the host never moving the address pins within the synchronizer-plus-filter latency after the combined write condition starts. They also rely on the host never moving the data pins within that latency after the condition ends, because both buses are sampled without their own delay line. The stimulus holds every pin for ten clocks around each strobe edge, which is longer than the two synchronizer stages plus three filter samples. The bench changes the address only after the later falling edge has settled and changes the data only after the earlier rising edge has settled. This makes a capture on the wrong edge visible as a wrong value. Glitch pulses are exactly two samples long, one short of the filter length, and are aligned so that the synchronizer passes them without stretching.

// File: rtl/flash_busop_pkg.sv
package flash_busop_pkg;

  typedef enum logic [2:0] {
    OP_STANDBY   = 3'd0,
    OP_OUT_DIS   = 3'd1,
    OP_READ      = 3'd2,
    OP_WRITE     = 3'd3,
    OP_AUTO_STBY = 3'd4
  } bus_op_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/flash_strobe_sync.sv
module flash_strobe_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/flash_glitch_filter.sv
module flash_glitch_filter #(
  parameter int SAMPLES = 3,
  parameter bit INIT    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  generate
    if (SAMPLES <= 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) dout <= INIT;
        else     dout <= din;
      end
    end else begin : g_count
      localparam int CW = $clog2(SAMPLES);
      logic [CW-1:0] run;

      // Output follows only after SAMPLES consecutive differing samples.
      always_ff @(posedge clk) begin
        if (rst) begin
          dout <= INIT;
          run  <= '0;
        end else if (din == dout) begin
          run <= '0;
        end else if (run == CW'(SAMPLES - 1)) begin
          dout <= din;
          run  <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/flash_idle_timer.sv
module flash_idle_timer #(
  parameter int LIMIT = 75,
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] strobes,
  output logic             idle
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0]    quiet;
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= '1;
      quiet <= '0;
    end else begin
      prev <= strobes;
      if (strobes != prev)           quiet <= '0;
      else if (quiet != CW'(LIMIT))  quiet <= quiet + 1'b1;
    end
  end

  assign idle = (quiet == CW'(LIMIT));

endmodule

// File: rtl/flash_write_capture.sv
module flash_write_capture #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_f,
  input  logic              we_f,
  input  logic              oe_s,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_err
);

  logic              act, act_q, err_seen;
  logic [ADDR_W-1:0] addr_lat;

  assign act = !ce_f && !we_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      err_seen <= 1'b0;
      addr_lat <= '0;
      wr_valid <= 1'b0;
      wr_err   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      act_q    <= act;
      wr_valid <= 1'b0;
      wr_err   <= 1'b0;
      if (act && !act_q) begin
        addr_lat <= addr_i;
        err_seen <= !oe_s;
      end else if (act && !oe_s) begin
        err_seen <= 1'b1;
      end
      if (!act && act_q) begin
        if (err_seen) begin
          wr_err <= 1'b1;
        end else begin
          wr_valid <= 1'b1;
          wr_addr  <= addr_lat;
          wr_data  <= dq_i;
        end
      end
    end
  end

endmodule

// File: rtl/flash_busop_fe.sv
module flash_busop_fe
  import flash_busop_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_PS   = 2000,
  parameter int GLITCH_PS   = 5000,
  parameter int IDLE_PS     = 150000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic [2:0]        bus_op,
  output logic              low_pwr,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_err
);

  localparam int GLITCH_SAMPLES = ceil_div(GLITCH_PS, SAMPLE_PS);
  localparam int IDLE_SAMPLES   = ceil_div(IDLE_PS, SAMPLE_PS);
  localparam int NSTROBE        = 3;
  localparam int NFILT          = 2;

  logic [NSTROBE-1:0] pins_s;
  logic [NFILT-1:0]   filt;
  logic               ce_f, we_f, oe_s, idle;
  bus_op_e            op_nxt;

  // bit 0 chip-select, bit 1 write strobe, bit 2 output strobe
  flash_strobe_sync #(.STAGES(SYNC_STAGES), .WIDTH(NSTROBE)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({oe_n, we_n, ce_n}),
    .dout(pins_s)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NFILT; gi++) begin : g_filt
      flash_glitch_filter #(.SAMPLES(GLITCH_SAMPLES), .INIT(1'b1)) u_filt (
        .clk (clk),
        .rst (rst),
        .din (pins_s[gi]),
        .dout(filt[gi])
      );
    end
  endgenerate

  assign ce_f = filt[0];
  assign we_f = filt[1];
  assign oe_s = pins_s[2];

  flash_idle_timer #(.LIMIT(IDLE_SAMPLES), .WIDTH(NSTROBE)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .strobes({oe_s, we_f, ce_f}),
    .idle   (idle)
  );

  flash_write_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wcap (
    .clk     (clk),
    .rst     (rst),
    .ce_f    (ce_f),
    .we_f    (we_f),
    .oe_s    (oe_s),
    .addr_i  (addr_i),
    .dq_i    (dq_i),
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_err  (wr_err)
  );

  always_comb begin
    if (ce_f)       op_nxt = OP_STANDBY;
    else if (idle)  op_nxt = OP_AUTO_STBY;
    else if (!we_f) op_nxt = OP_WRITE;
    else if (!oe_s) op_nxt = OP_READ;
    else            op_nxt = OP_OUT_DIS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_op  <= OP_STANDBY;
      dq_oe   <= 1'b0;
      dq_o    <= '0;
      low_pwr <= 1'b0;
    end else begin
      bus_op  <= op_nxt;
      dq_oe   <= !ce_f && !oe_s && we_f;
      dq_o    <= rd_data_i;
      low_pwr <= !busy && (ce_f || idle);
    end
  end

endmodule

// File: rtl/flash_busop_chk.sv
module flash_busop_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              dq_oe,
  input logic [2:0]        bus_op,
  input logic              low_pwr,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_err
);

  p_oe_only_read_r2: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (bus_op == 3'd2 || bus_op == 3'd4));

  p_standby_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_op == 3'd0) |-> !dq_oe);

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  p_data_moves_on_valid_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_data) |-> wr_valid);

  p_addr_moves_on_valid_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_addr) |-> wr_valid);

  p_err_excludes_valid_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && wr_err));

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> !wr_err);

  p_busy_blocks_lp_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> !low_pwr);

  p_op_legal_r8: assert property (@(posedge clk) disable iff (rst)
    bus_op <= 3'd4);

endmodule

bind flash_busop_fe flash_busop_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .dq_oe   (dq_oe),
  .bus_op  (bus_op),
  .low_pwr (low_pwr),
  .wr_valid(wr_valid),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .wr_err  (wr_err)
);

// File: tb/flash_busop_fe_test.sv
`timescale 1ns/1ps
module flash_busop_fe_test;

  localparam int AW = 18;
  localparam int DW = 16;
  localparam int GLITCH = (5000 + 1999) / 2000;     // 3 samples
  localparam int IDLE   = (150000 + 1999) / 2000;   // 75 samples
  localparam int SETTLE = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] dq_i = '0, rd_data_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe, low_pwr, wr_valid, wr_err;
  logic [2:0]    bus_op;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int n_checks = 0, n_fail = 0;
  int n_valid = 0, n_err = 0;
  logic [AW-1:0] got_addr;
  logic [DW-1:0] got_data;

  always #4 clk = ~clk;

  flash_busop_fe uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .busy(busy),
    .addr_i(addr_i), .dq_i(dq_i), .rd_data_i(rd_data_i), .dq_o(dq_o),
    .dq_oe(dq_oe), .bus_op(bus_op), .low_pwr(low_pwr), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err)
  );

  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      n_valid++;
      got_addr = wr_addr;
      got_data = wr_data;
    end
    if (!rst && wr_err) n_err++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    wait_n(5);
    rst = 1'b0;
    wait_n(1);
    chk(bus_op == 3'd0, "R1 bus_op", bus_op, 0);
    chk(dq_oe == 1'b0, "R1 dq_oe", dq_oe, 0);
    chk(n_valid == 0 && n_err == 0, "R1 no pulses", n_valid + n_err, 0);
    wait_n(4);
    chk(low_pwr == 1'b1, "R11 standby low_pwr", low_pwr, 1);
  endtask

  task automatic t_read;
    rd_data_i = 16'hA5C3;
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    wait_n(SETTLE);
    chk(bus_op == 3'd2, "R2 bus_op", bus_op, 2);
    chk(dq_oe == 1'b1, "R2 dq_oe", dq_oe, 1);
    chk(dq_o == 16'hA5C3, "R2 dq_o", dq_o, 16'hA5C3);
    rd_data_i = 16'h1234;
    wait_n(2);
    chk(dq_o == 16'h1234, "R2 dq_o follows", dq_o, 16'h1234);
  endtask

  task automatic t_outdis;
    oe_n = 1'b1;
    wait_n(SETTLE);
    chk(bus_op == 3'd1, "R3 bus_op", bus_op, 1);
    chk(dq_oe == 1'b0, "R3 dq_oe", dq_oe, 0);
    chk(low_pwr == 1'b0, "R10 active bus not low power", low_pwr, 0);
  endtask

  task automatic t_standby;
    oe_n = 1'b0; ce_n = 1'b1;
    wait_n(SETTLE);
    chk(bus_op == 3'd0, "R4 bus_op oe low", bus_op, 0);
    chk(dq_oe == 1'b0, "R4 dq_oe oe low", dq_oe, 0);
    we_n = 1'b0;
    wait_n(SETTLE);
    chk(bus_op == 3'd0 && dq_oe == 1'b0, "R4 we low", bus_op, 0);
    chk(n_valid == 0 && n_err == 0, "R4 no write", n_valid + n_err, 0);
    we_n = 1'b1; oe_n = 1'b1;
    wait_n(SETTLE);
  endtask

  // ce first down, we up first: address at we fall, data at we rise
  task automatic t_write_ce_first;
    int v0 = n_valid;
    addr_i = 18'h0AAAA; dq_i = 16'h0000;
    ce_n = 1'b0;
    wait_n(SETTLE);
    addr_i = 18'h15555;
    we_n = 1'b0;
    wait_n(SETTLE);
    chk(bus_op == 3'd3, "R5 bus_op write", bus_op, 3);
    addr_i = 18'h3FFFF;
    dq_i = 16'hBEEF;
    wait_n(SETTLE);
    we_n = 1'b1;
    wait_n(SETTLE);
    dq_i = 16'hDEAD;
    wait_n(SETTLE);
    ce_n = 1'b1;
    wait_n(SETTLE);
    chk(n_valid == v0 + 1, "R5 one valid (ce first)", n_valid - v0, 1);
    chk(got_addr == 18'h15555, "R5 addr at later fall", got_addr, 18'h15555);
    chk(got_data == 16'hBEEF, "R5 data at earlier rise", got_data, 16'hBEEF);
  endtask

  // we first down, ce up first: address at ce fall, data at ce rise
  task automatic t_write_we_first;
    int v0 = n_valid;
    addr_i = 18'h00011; dq_i = 16'h0000;
    we_n = 1'b0;
    wait_n(SETTLE);
    addr_i = 18'h22222;
    ce_n = 1'b0;
    wait_n(SETTLE);
    addr_i = 18'h00033;
    dq_i = 16'h7E81;
    wait_n(SETTLE);
    ce_n = 1'b1;
    wait_n(SETTLE);
    dq_i = 16'h0F0F;
    wait_n(SETTLE);
    we_n = 1'b1;
    wait_n(SETTLE);
    chk(n_valid == v0 + 1, "R5 one valid (we first)", n_valid - v0, 1);
    chk(got_addr == 18'h22222, "R5 addr at ce fall", got_addr, 18'h22222);
    chk(got_data == 16'h7E81, "R5 data at ce rise", got_data, 16'h7E81);
  endtask

  task automatic t_write_err;
    int v0 = n_valid;
    int e0 = n_err;
    addr_i = 18'h00444; dq_i = 16'h4444;
    ce_n = 1'b0;
    wait_n(SETTLE);
    we_n = 1'b0;
    wait_n(SETTLE);
    oe_n = 1'b0;
    wait_n(SETTLE);
    oe_n = 1'b1;
    wait_n(SETTLE);
    we_n = 1'b1;
    wait_n(SETTLE);
    ce_n = 1'b1;
    wait_n(SETTLE);
    chk(n_err == e0 + 1, "R6 one error", n_err - e0, 1);
    chk(n_valid == v0, "R6 no valid", n_valid - v0, 0);
  endtask

  task automatic t_glitch;
    int v0 = n_valid;
    int e0 = n_err;
    int drops = 0;
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    wait_n(SETTLE);
    for (int i = 0; i < GLITCH - 1; i++) begin we_n = 1'b0; @(negedge clk); end
    we_n = 1'b1;
    wait_n(SETTLE);
    chk(n_valid == v0 && n_err == e0, "R7 we glitch no write", n_valid - v0, 0);
    chk(bus_op == 3'd1, "R7 we glitch op", bus_op, 1);
    oe_n = 1'b0;
    wait_n(SETTLE);
    for (int i = 0; i < GLITCH - 1; i++) begin ce_n = 1'b1; @(negedge clk); end
    ce_n = 1'b0;
    for (int i = 0; i < SETTLE; i++) begin
      if (!dq_oe || bus_op != 3'd2) drops++;
      @(negedge clk);
    end
    chk(drops == 0, "R7 ce glitch keeps read", drops, 0);
  endtask

  task automatic t_auto;
    rd_data_i = 16'h5A5A;
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    wait_n(SETTLE);
    oe_n = 1'b1;
    wait_n(SETTLE);
    oe_n = 1'b0;
    wait_n(IDLE / 2);
    chk(low_pwr == 1'b0, "R8 not yet idle", low_pwr, 0);
    wait_n(IDLE);
    chk(bus_op == 3'd4, "R8 auto standby op", bus_op, 4);
    chk(low_pwr == 1'b1, "R8 low_pwr", low_pwr, 1);
    chk(dq_oe == 1'b1 && dq_o == 16'h5A5A, "R8 read still driven", dq_oe, 1);
    busy = 1'b1;
    wait_n(3);
    chk(low_pwr == 1'b0, "R9 busy in auto standby", low_pwr, 0);
    busy = 1'b0;
    wait_n(3);
    chk(low_pwr == 1'b1, "R9 busy released", low_pwr, 1);
    oe_n = 1'b1;
    wait_n(SETTLE);
    chk(low_pwr == 1'b0, "R10 transition wakes", low_pwr, 0);
    chk(bus_op == 3'd1, "R10 op after wake", bus_op, 1);
  endtask

  task automatic t_busy_standby;
    ce_n = 1'b1;
    wait_n(SETTLE);
    chk(low_pwr == 1'b1, "R11 standby again", low_pwr, 1);
    busy = 1'b1;
    wait_n(3);
    chk(low_pwr == 1'b0, "R9 busy in standby", low_pwr, 0);
    busy = 1'b0;
    wait_n(3);
  endtask

  initial begin
    #(8 * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_read();
    t_outdis();
    t_standby();
    t_write_ce_first();
    t_write_we_first();
    t_write_err();
    t_glitch();
    t_auto();
    t_busy_standby();
    finish_run();
  end

endmodule